// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block performs clean and invalidate maintenance on a cache by walking over cache lines on behalf of a requester. The requester writes a start address to one register and then an end address to a second register. Each write carries an operation code. The end-address write launches the walk. The engine then issues one line-maintenance command per 32-byte cache line to the tag/data-array port, using a command/acknowledge handshake. `busy` holds the requester stalled until the array has acknowledged the last command.

The same register port also launches single-line clean, invalidate and clean-plus-invalidate operations, and an invalidate-all operation that steps through every set index. A range is rejected with a one-cycle error pulse, and nothing is issued, in either of two cases: its end lies below its start, or its start and end fall in different 4 KB pages. Range checks are needed because only the start address is translated.

Top module: `cache_range_engine`

## Requirements
- R1: After reset `busy`, `cmdValid` and `errFlag` are all 0.
- R2: A write with `regSel`=1 and `regOp` 0 (clean range) or 1 (invalidate range) issues one command per line, in ascending order. The lines run from the stored start line to the written end line, both included, with the address stepping by 32. `cmdKind` is 0 (clean) for operation 0 and 1 (invalidate) for operation 1.
- R3: Address bits 4:0 of start and end writes are ignored. Command addresses are line-aligned, with bits 4:0 equal to 0.
- R4: Each command is held, with stable `cmdAddr` and `cmdKind`, until `cmdAck` is sampled high. `busy` rises at the clock edge that takes the launching write and falls at the edge that takes the last acknowledge. With an acknowledge delay of d cycles, `busy` is therefore high for n·(d+1) cycles for n commands.
- R5: A range trigger whose start and end lie in different 4 KB pages pulses `errFlag` for one cycle and issues no command.
- R6: A range trigger whose end line is below the start line pulses `errFlag` for one cycle and issues no command.
- R7: A write with `regOp` 2, 3 or 4, to either register, issues exactly one command at the line-aligned write address. The `cmdKind` values are 0 for operation 2, 2 (clean+invalidate) for operation 3, and 1 for operation 4.
- R8: A write with `regOp` 5 issues NUM_SETS commands with `cmdKind` 3 (set invalidate). `cmdAddr` carries the set index, from 0 up to NUM_SETS-1.
- R9: A start write (`regSel`=0) with a range operation issues nothing and leaves the engine idle. A later start write replaces the stored start.
- R10: Register writes made while `busy` is high are ignored. They change neither the walk nor the stored start.
- R11: Writes with `regOp` 6 or 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = start-address register, 1 = end-address (trigger) register |
| regOp | input | 3 | Operation code carried with the write |
| regData | input | ADDR_W | Address written |
| busy | output | 1 | Requester stall, high while a walk runs |
| errFlag | output | 1 | One-cycle pulse on a rejected range |
| cmdValid | output | 1 | Line command valid toward the array port |
| cmdKind | output | 2 | 0 clean, 1 invalidate, 2 clean+invalidate, 3 set invalidate |
| cmdAddr | output | ADDR_W | Line address, or set index for kind 3 |
| cmdAck | input | 1 | Array acknowledges the current command |

## Verification
A write presented before a rising edge shows its effect at the next falling edge. At that point `busy` and the first `cmdValid`/`cmdAddr` are already visible, and so is the `errFlag` pulse for a rejected range. The bench therefore samples all results on falling edges. Each following command appears one cycle after the edge that took the previous acknowledge. `busy` is already low at the falling edge after the last acknowledge, so the bench counts high-`busy` falling edges and compares the count with n·(d+1) for its programmed acknowledge delay d. A sweep over start and end line pairs, low-bit offsets, both range operations and two acknowledge delays compares every issued command against arithmetic expectations.

// File: rtl/crm_pkg.sv
package crm_pkg;

  localparam logic [2:0] OP_CLEAN_RANGE = 3'd0;
  localparam logic [2:0] OP_INV_RANGE   = 3'd1;
  localparam logic [2:0] OP_CLEAN_LINE  = 3'd2;
  localparam logic [2:0] OP_FLUSH_LINE  = 3'd3;
  localparam logic [2:0] OP_INV_LINE    = 3'd4;
  localparam logic [2:0] OP_INV_ALL     = 3'd5;

  typedef enum logic [1:0] {
    CMD_CLEAN     = 2'd0,
    CMD_INV       = 2'd1,
    CMD_CLEAN_INV = 2'd2,
    CMD_SET_INV   = 2'd3
  } cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadStart;
    logic     launchRange;
    logic     launchLine;
    logic     launchAll;
    logic     advance;
    cmdKind_e kind;
  } ctrlStrobe_t;

endpackage

// File: rtl/crm_ctrl.sv
module crm_ctrl
  import crm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [2:0]  regOp,
  input  logic        rangeBad,
  input  logic        isLast,
  input  logic        cmdAck,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        errFlag
);

  typedef enum logic {ST_IDLE, ST_WALK} state_e;

  state_e stateQ, stateNext;
  logic   errNext;

  always_comb begin
    strobe    = '0;
    errNext   = 1'b0;
    stateNext = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (regWrEn) begin
          case (regOp)
            OP_CLEAN_RANGE, OP_INV_RANGE: begin
              if (!regSel) begin
                strobe.loadStart = 1'b1;
              end else if (rangeBad) begin
                errNext = 1'b1;
              end else begin
                strobe.launchRange = 1'b1;
                strobe.kind = (regOp == OP_CLEAN_RANGE) ? CMD_CLEAN : CMD_INV;
                stateNext = ST_WALK;
              end
            end
            OP_CLEAN_LINE: begin
              strobe.launchLine = 1'b1;
              strobe.kind = CMD_CLEAN;
              stateNext = ST_WALK;
            end
            OP_FLUSH_LINE: begin
              strobe.launchLine = 1'b1;
              strobe.kind = CMD_CLEAN_INV;
              stateNext = ST_WALK;
            end
            OP_INV_LINE: begin
              strobe.launchLine = 1'b1;
              strobe.kind = CMD_INV;
              stateNext = ST_WALK;
            end
            OP_INV_ALL: begin
              strobe.launchAll = 1'b1;
              strobe.kind = CMD_SET_INV;
              stateNext = ST_WALK;
            end
            default: ;
          endcase
        end
      end
      ST_WALK: begin
        if (cmdAck) begin
          if (isLast) stateNext = ST_IDLE;
          else        strobe.advance = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      stateQ  <= stateNext;
      errFlag <= errNext;
    end
  end

  assign busy = (stateQ == ST_WALK);

  // R5/R6: a rejected range never starts a walk
  a_r5_err_no_walk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !busy);

  // R10: writes during a walk cannot end it early
  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && !cmdAck) |=> busy);

endmodule

// File: rtl/crm_datapath.sv
module crm_datapath
  import crm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_SETS   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regData,
  input  logic              busy,
  output logic              rangeBad,
  output logic              isLast,
  output logic [ADDR_W-1:0] cmdAddr,
  output cmdKind_e          cmdKind
);

  localparam int LINE_BITS  = $clog2(LINE_BYTES);
  localparam int IDX_W      = ADDR_W - LINE_BITS;
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES) - LINE_BITS;
  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(NUM_SETS - 1);

  logic [IDX_W-1:0] startLine, curLine, endLine, wrLine;
  logic             modeAll;
  logic             unusedLowBits;

  assign wrLine        = regData[ADDR_W-1:LINE_BITS];
  assign unusedLowBits = ^regData[LINE_BITS-1:0];

  // end below start, or start and end in different pages
  assign rangeBad = (wrLine < startLine) ||
                    (wrLine[IDX_W-1:PAGE_SHIFT] != startLine[IDX_W-1:PAGE_SHIFT]);

  assign isLast = (curLine == endLine);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startLine <= '0;
      curLine   <= '0;
      endLine   <= '0;
      modeAll   <= 1'b0;
      cmdKind   <= CMD_CLEAN;
    end else begin
      if (strobe.loadStart) startLine <= wrLine;
      if (strobe.launchRange) begin
        curLine <= startLine;
        endLine <= wrLine;
        modeAll <= 1'b0;
        cmdKind <= strobe.kind;
      end else if (strobe.launchLine) begin
        curLine <= wrLine;
        endLine <= wrLine;
        modeAll <= 1'b0;
        cmdKind <= strobe.kind;
      end else if (strobe.launchAll) begin
        curLine <= '0;
        endLine <= LAST_SET;
        modeAll <= 1'b1;
        cmdKind <= strobe.kind;
      end else if (strobe.advance) begin
        curLine <= curLine + 1'b1;
      end
    end
  end

  assign cmdAddr = modeAll ? ADDR_W'(curLine) : {curLine, {LINE_BITS{1'b0}}};

  // R2: the walk pointer never passes the end line
  a_r2_within_end: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (curLine <= endLine));

  // R8: set walk stays inside the set count
  a_r8_set_bound: assert property (@(posedge clk) disable iff (!rstN)
    (busy && modeAll) |-> (curLine <= LAST_SET));

endmodule

// File: rtl/cache_range_engine.sv
module cache_range_engine
  import crm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_SETS   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [2:0]        regOp,
  input  logic [ADDR_W-1:0] regData,
  output logic              busy,
  output logic              errFlag,
  output logic              cmdValid,
  output logic [1:0]        cmdKind,
  output logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdAck
);

  ctrlStrobe_t strobe;
  logic        rangeBad;
  logic        isLast;
  cmdKind_e    kindQ;

  crm_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regOp    (regOp),
    .rangeBad (rangeBad),
    .isLast   (isLast),
    .cmdAck   (cmdAck),
    .strobe   (strobe),
    .busy     (busy),
    .errFlag  (errFlag)
  );

  crm_datapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_SETS   (NUM_SETS)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regData  (regData),
    .busy     (busy),
    .rangeBad (rangeBad),
    .isLast   (isLast),
    .cmdAddr  (cmdAddr),
    .cmdKind  (kindQ)
  );

  assign cmdValid = busy;
  assign cmdKind  = kindQ;

  // R4: an unacknowledged command is held unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdKind)));

  // R2: after an acknowledge the walk either ends or moves upward
  a_r2_ascend: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAck) |=> (!cmdValid || (cmdAddr > $past(cmdAddr))));

endmodule

// File: tb/test_cache_range_engine.sv
`timescale 1ns/1ps
module test_cache_range_engine;

  localparam int NSETS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [2:0]  regOp = 3'd0;
  logic [31:0] regData = 32'd0;
  logic        cmdAck = 1'b0;
  logic        busy, errFlag, cmdValid;
  logic [1:0]  cmdKind;
  logic [31:0] cmdAddr;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  int ackDelay = 0;
  int waitCnt = 0;
  int logCount = 0;
  int busyCycles = 0;
  logic [31:0] logAddr [0:63];
  logic [1:0]  logKind [0:63];
  logic errSeen, busySeen;

  cache_range_engine #(.NUM_SETS(NSETS)) i_cache_range_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regOp(regOp),
    .regData(regData), .busy(busy), .errFlag(errFlag), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdAck(cmdAck)
  );

  always #2.5 clk = ~clk;

  // array port model with programmable acknowledge delay
  always @(negedge clk) begin
    if (busy) busyCycles++;
    if (cmdValid) begin
      if (waitCnt == ackDelay) begin
        if (logCount < 64) begin
          logAddr[logCount] = cmdAddr;
          logKind[logCount] = cmdKind;
        end
        logCount++;
        cmdAck  = 1'b1;
        waitCnt = 0;
      end else begin
        cmdAck = 1'b0;
        waitCnt++;
      end
    end else begin
      cmdAck  = 1'b0;
      waitCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    logCount = 0;
    busyCycles = 0;
  endtask

  task automatic wr(input bit sel, input logic [2:0] op, input logic [31:0] data);
    regWrEn = 1'b1; regSel = sel; regOp = op; regData = data;
    @(negedge clk);
    errSeen = errFlag;
    busySeen = busy;
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic runRange(input logic [2:0] op, input logic [31:0] s, input logic [31:0] e, input int d);
    int sl, el, n, bad;
    ackDelay = d;
    clearLog();
    wr(1'b0, op, s);
    wr(1'b1, op, e);
    waitIdle();
    sl = int'(s >> 5);
    el = int'(e >> 5);
    if (el < sl) begin
      chk(errSeen == 1'b1 && logCount == 0, "R6 end below start", logCount, 0);
    end else if ((s >> 12) != (e >> 12)) begin
      chk(errSeen == 1'b1 && logCount == 0, "R5 page crossing", logCount, 0);
    end else begin
      n = el - sl + 1;
      chk(errSeen == 1'b0 && logCount == n, "R2 line count", logCount, n);
      bad = 0;
      for (int k = 0; k < n && k < 64; k++) begin
        if (logAddr[k] != ((s & ~32'h1f) + 32'(k * 32))) bad++;
        if (logKind[k] != ((op == 3'd0) ? 2'd0 : 2'd1)) bad++;
      end
      chk(bad == 0, "R2/R3 addresses and kinds", bad, 0);
      chk(busyCycles == n * (d + 1), "R4 busy length", busyCycles, n * (d + 1));
    end
  endtask

  task automatic runLine(input bit sel, input logic [2:0] op, input logic [31:0] a, input logic [1:0] k, input int d);
    ackDelay = d;
    clearLog();
    wr(sel, op, a);
    waitIdle();
    chk(logCount == 1, "R7 one command", logCount, 1);
    chk(logAddr[0] == (a & ~32'h1f) && logKind[0] == k, "R7 line address/kind",
        {logKind[0], logAddr[0]}, {k, a & ~32'h1f});
    chk(busyCycles == d + 1, "R4 line busy length", busyCycles, d + 1);
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && cmdValid == 0 && errFlag == 0, "R1 reset outputs",
        {busy, cmdValid, errFlag}, 0);

    // R2/R3/R4/R6 sweep
    for (int op = 0; op < 2; op++)
      for (int d = 0; d < 3; d += 2)
        for (int sl = 0; sl < 6; sl++)
          for (int el = 0; el < 6; el++)
            runRange(3'(op), 32'(32'h3000 + sl * 32 + ((sl * 7) & 31)),
                     32'(32'h3000 + el * 32 + ((el * 13) & 31)), d);

    // R5 page boundary cases
    runRange(3'd0, 32'h3FE0, 32'h4000, 0);
    runRange(3'd1, 32'h3FC3, 32'h3FFF, 1);
    runRange(3'd1, 32'h1000, 32'h2FE0, 0);
    // R3 low bits
    runRange(3'd0, 32'h201F, 32'h2040, 0);

    // R9 start write alone, then overwrite
    clearLog();
    wr(1'b0, 3'd0, 32'h7000);
    repeat (4) @(negedge clk);
    chk(busy == 0 && logCount == 0, "R9 start alone idle", logCount, 0);
    wr(1'b0, 3'd1, 32'h7100);
    wr(1'b1, 3'd1, 32'h7120);
    waitIdle();
    chk(logCount == 2 && logAddr[0] == 32'h7100 && logAddr[1] == 32'h7120,
        "R9 start overwritten", logAddr[0], 32'h7100);

    // R7 single-line operations
    runLine(1'b1, 3'd2, 32'h1234_5677, 2'd0, 0);
    runLine(1'b0, 3'd3, 32'h0000_0FFF, 2'd2, 1);
    runLine(1'b1, 3'd4, 32'hFFFF_FFE1, 2'd1, 3);

    // R8 invalidate all
    for (int d = 0; d < 2; d++) begin
      ackDelay = d;
      clearLog();
      wr(1'b1, 3'd5, 32'hABCD_0000);
      waitIdle();
      chk(logCount == NSETS, "R8 set count", logCount, NSETS);
      bad = 0;
      for (int k = 0; k < NSETS; k++)
        if (logAddr[k] != 32'(k) || logKind[k] != 2'd3) bad++;
      chk(bad == 0, "R8 set indices", bad, 0);
      chk(busyCycles == NSETS * (d + 1), "R4 set walk busy", busyCycles, NSETS * (d + 1));
    end

    // R10 writes during a walk
    ackDelay = 3;
    clearLog();
    wr(1'b0, 3'd0, 32'h5000);
    wr(1'b1, 3'd0, 32'h5060);
    wr(1'b0, 3'd0, 32'h5FE0);
    wr(1'b1, 3'd4, 32'h9000);
    waitIdle();
    bad = 0;
    for (int k = 0; k < 4; k++)
      if (logAddr[k] != 32'(32'h5000 + k * 32) || logKind[k] != 2'd0) bad++;
    chk(logCount == 4 && bad == 0, "R10 walk unchanged", logCount, 4);
    ackDelay = 0;
    clearLog();
    wr(1'b1, 3'd1, 32'h50A0);
    waitIdle();
    chk(errSeen == 0 && logCount == 6 && logAddr[0] == 32'h5000,
        "R10 stored start unchanged", logCount, 6);

    // R11 unused operation codes
    clearLog();
    wr(1'b1, 3'd6, 32'h0100);
    chk(busySeen == 0 && errSeen == 0, "R11 op 6 ignored", busySeen, 0);
    wr(1'b0, 3'd7, 32'h0200);
    chk(busySeen == 0 && errSeen == 0, "R11 op 7 ignored", busySeen, 0);
    repeat (3) @(negedge clk);
    chk(logCount == 0, "R11 no commands", logCount, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule